// File: doc/BRIEF.md
# Grayscale PWM channel controller

This block generates pulse-width modulated enables for a bank of output channels that share one grayscale counter. Each channel has a 12-bit intensity value. The counter advances on the grayscale clock. A blanking input holds the counter and forces every enable low. When blanking is released, a new PWM cycle begins.

On the first grayscale clock edge after blanking drops, the counter steps to one and every channel with a nonzero value switches on. Each channel stays on while the counter does not exceed its value, so a value of N gives N clock periods of on time. A cycle is 4096 clock pulses long. After the last pulse every enable is low and the counter is frozen. The next cycle needs blanking to be raised and dropped again. Reset leaves the block in this frozen state.

Top module: `gs_pwm`

## Requirements
- R1: After reset, with blanking low, all enables stay low and no cycle starts until blanking has been raised and lowered.
- R2: While blanking is high, every enable is low and the counter is held at zero.
- R3: On the first clock edge after blanking falls, every channel whose value is nonzero turns on.
- R4: A channel with value N (1 to 4095), where channel i occupies bits [12*i+11:12*i] of the value bus, is on for exactly N clock periods of the cycle. It turns off at the edge where the counter becomes greater than N.
- R5: A channel with value zero stays off for the whole cycle.
- R6: A cycle lasts 4096 clock pulses. After the last pulse all enables are low and stay low while blanking remains low.
- R7: Raising and lowering blanking after a completed cycle starts a new full cycle with the current values.
- R8: Raising blanking in the middle of a cycle turns all enables off immediately. Lowering it again starts a fresh cycle from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock; the counter advances on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank | input | 1 | High: enables off and counter held at zero; falling starts a cycle |
| gs_vals | input | 192 | Sixteen 12-bit grayscale values, channel 0 in the low bits |
| out_en | output | 16 | Per-channel on enable |

## Verification
Two value sets are run through full cycles. Each set mixes zero, one, small odd values, mid-scale values, powers of two and the top codes 4094 and 4095. Measuring the on time of each channel separates a correct compare boundary from an off-by-one error, and the zero channels show whether the turn-on gate is right. Idle clocks after the cycle ends show whether the counter stops or wraps. A reset with blanking held low shows whether the block wrongly starts a cycle. A cycle aborted partway and then restarted shows whether blanking clears the counter and gates the outputs at once.

// File: rtl/gs_pwm.sv
module gs_pwm #(
  parameter int CHANNELS = 16,
  parameter int GS_BITS  = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         blank,
  input  logic [CHANNELS*GS_BITS-1:0]  gs_vals,
  output logic [CHANNELS-1:0]          out_en
);
  localparam int CW = GS_BITS + 1;
  localparam logic [CW-1:0] CYCLE_END = {1'b1, {GS_BITS{1'b0}}};

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= CYCLE_END;
    else if (blank)            cnt <= '0;
    else if (cnt != CYCLE_END) cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [GS_BITS-1:0] v;
    assign v = gs_vals[i*GS_BITS +: GS_BITS];
    assign out_en[i] = !blank && (cnt != '0) && (cnt <= {1'b0, v});

    AST_ZERO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (v == '0) |-> !out_en[i]); // R5
    AST_FIRST_EDGE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank && cnt == CW'(1)) |-> (out_en[i] == (v != '0))); // R3
    AST_OFF_PAST_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank && cnt > {1'b0, v}) |-> !out_en[i]); // R4
  end

  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (cnt == '0)); // R2
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (out_en == '0)); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && cnt != CYCLE_END) |=> (blank || cnt == $past(cnt) + 1'b1)); // R4
  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && cnt == CYCLE_END) |=> (blank || cnt == CYCLE_END)); // R6
  AST_END_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CYCLE_END) |-> (out_en == '0)); // R6
endmodule

// File: tb/gs_pwm_bench.sv
module gs_pwm_bench;
  localparam int NCH = 16;
  localparam int GB  = 12;
  localparam int FULL = 4096;

  logic clk = 0;
  logic rst_n = 0;
  logic blank = 0;
  logic [NCH*GB-1:0] gs_vals;
  logic [NCH-1:0] out_en;

  logic [GB-1:0] gsv [NCH];
  int on_cnt [NCH];
  int tests = 0, fails = 0;
  int k = FULL;
  string phase = "";
  logic [NCH-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) gs_vals[i*GB +: GB] = gsv[i];

  gs_pwm u_gs_pwm (.clk(clk), .rst_n(rst_n), .blank(blank), .gs_vals(gs_vals), .out_en(out_en));

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) if (out_en[i]) on_cnt[i]++;
    if (exp_q.size() > 0) begin
      logic [NCH-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (out_en !== e) begin
        fails++;
        $display("FAIL %s k=%0d out_en=%h expected %h", t, k, out_en, e);
      end
    end
  end

  task automatic step(input logic b);
    logic [NCH-1:0] e;
    string t;
    @(negedge clk); #1;
    blank = b;
    if (b) k = 0;
    else if (k < FULL) k++;
    e = '0;
    if (!b) for (int i = 0; i < NCH; i++) e[i] = (k >= 1) && (k <= int'(gsv[i]));
    if (phase != "") t = phase;
    else if (b) t = "R2";
    else if (k == 1) t = "R3";
    else if (k >= FULL) t = "R6";
    else t = "R4";
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NCH; i++) on_cnt[i] = 0;
  endtask

  task automatic check_counts(input string t);
    @(negedge clk); #1;
    for (int i = 0; i < NCH; i++) begin
      tests++;
      if (on_cnt[i] != int'(gsv[i])) begin
        fails++;
        $display("FAIL %s ch%0d on periods=%0d expected %0d",
                 (gsv[i] == 0 && t == "R4") ? "R5" : t, i, on_cnt[i], gsv[i]);
      end
    end
  endtask

  task automatic set_a();
    int a [NCH] = '{0,1,2,3,7,15,100,255,1000,2047,2048,3000,4000,4094,4095,512};
    for (int i = 0; i < NCH; i++) gsv[i] = GB'(a[i]);
  endtask

  task automatic set_b();
    int b [NCH] = '{4095,0,1,4094,9,17,300,1234,2222,3333,5,6,64,128,800,4093};
    for (int i = 0; i < NCH; i++) gsv[i] = GB'(b[i]);
  endtask

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    set_a();
    clear_counts();
    repeat (3) @(negedge clk);
    tests++;
    if (out_en !== '0) begin
      fails++;
      $display("FAIL R1 in reset out_en=%h expected 0", out_en);
    end
    #1 rst_n = 1;
    // R1: no cycle after reset without a blank pulse
    phase = "R1";
    repeat (10) step(1'b0);
    phase = "R2";
    repeat (5) step(1'b1);
    phase = "";
    clear_counts();
    repeat (FULL + 4) step(1'b0);
    check_counts("R4");
    // R6: stays dark after the cycle
    phase = "R6";
    repeat (20) step(1'b0);
    // R7: retrigger with new values
    set_b();
    phase = "R7";
    repeat (2) step(1'b1);
    clear_counts();
    repeat (FULL + 2) step(1'b0);
    check_counts("R7");
    // R8: abort mid-cycle and restart
    phase = "R8";
    repeat (2) step(1'b1);
    repeat (60) step(1'b0);
    repeat (3) step(1'b1);
    clear_counts();
    repeat (FULL + 2) step(1'b0);
    check_counts("R8");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule